// File: doc/BRIEF.md
# Seven-Channel Priority DMA Arbiter

This block decides which of seven DMA channels owns the memory bus. Software programs one 32-bit configuration word in which every channel has a 3-bit urgency value and an enable bit. The arbiter looks at the request lines of the enabled channels and grants the bus to the most urgent one. A lower value means more urgent. When several channels share the best value, the channel with the larger index wins.

A grant is sticky. The owning channel keeps the bus until it lowers its own request, so the owner changes only between bursts and never in the middle of one. After a release there is one idle cycle, and then a new winner is picked. While any channel holds the bus, a stall output tells the processor to keep off it.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After reset the configuration word reads 0x07654321, and grant, grant_valid and cpu_stall are all zero. Every enable bit is clear at that point, so no request is granted.
- R2: Channel n takes its urgency from configuration bits 4n+2..4n and its enable from bit 4n+3.
- R3: Among enabled, requesting channels, the one with the numerically lowest urgency value is granted (0 most urgent, 7 least).
- R4: When the best urgency value is shared, the requesting channel with the highest index is granted.
- R5: A channel whose enable bit is 0 is never given a new grant, even while it requests.
- R6: Bits 31:28 of the configuration word can be written and read back, and they do not change the arbitration result.
- R7: grant is one-hot or zero. When the arbiter is idle, the grant for a request seen at a clock edge appears at that same edge.
- R8: While the granted channel keeps its request high, grant stays unchanged, whatever the other requests do.
- R9: In the cycle after the owner lowers its request, grant is zero. At the following edge a new winner is taken from the requests present then.
- R10: grant_valid and cpu_stall both equal the OR of all grant bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Current configuration word |
| req | input | 7 | Per-channel bus request |
| grant | output | 7 | One-hot bus grant |
| grant_valid | output | 1 | Some channel owns the bus |
| cpu_stall | output | 1 | Processor must stay off the bus |

## Verification
The assertions assume that the requests a channel raises are meant for the whole burst. They also assume that the configuration word only changes while the arbiter is idle, because a new enable mask does not revoke a grant that is already held. The stimulus follows both rules. It writes the word and lowers every request before each table vector. It then raises the new request set for one edge, samples grant, and lowers the requests for two idle cycles. The hold test is the only case that raises extra requests while the bus is owned, which is exactly what R8 and R9 describe.

// File: rtl/dmaarb_pkg.sv
package dmaarb_pkg;
   localparam int unsigned MAX_CH = 16;
   typedef enum logic {
      ARB_IDLE = 1'b0,
      ARB_OWN  = 1'b1
   } arb_state_e;
endpackage

// File: rtl/dmaarb_cfg_reg.sv
module dmaarb_cfg_reg #(
   parameter int unsigned REG_W     = 32,
   parameter logic [REG_W-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST_VAL;
      else if (we) q <= wdata;
   end
endmodule

// File: rtl/dmaarb_pick.sv
module dmaarb_pick #(
   parameter int unsigned NUM_CH  = 7,
   parameter int unsigned PRIO_W  = 3,
   parameter bit          TIE_HIGH = 1'b1,
   localparam int unsigned FIELD_W = PRIO_W + 1,
   localparam int unsigned USED_W  = NUM_CH * FIELD_W
) (
   input  logic [USED_W-1:0] cfg,
   input  logic [NUM_CH-1:0] req,
   output logic [NUM_CH-1:0] win_oh,
   output logic              win_any
);
   logic [PRIO_W-1:0] prio [NUM_CH];
   logic [NUM_CH-1:0] elig;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_field
      assign prio[c] = cfg[c*FIELD_W +: PRIO_W];
      assign elig[c] = req[c] & cfg[c*FIELD_W + PRIO_W];
   end

   logic [PRIO_W-1:0] best;
   logic              found;

   if (TIE_HIGH) begin : g_tie_high
      always_comb begin
         best   = '1;
         found  = 1'b0;
         win_oh = '0;
         for (int c = 0; c < NUM_CH; c++) begin
            if (elig[c] && (!found || prio[c] <= best)) begin
               best      = prio[c];
               found     = 1'b1;
               win_oh    = '0;
               win_oh[c] = 1'b1;
            end
         end
      end
   end else begin : g_tie_low
      always_comb begin
         best   = '1;
         found  = 1'b0;
         win_oh = '0;
         for (int c = 0; c < NUM_CH; c++) begin
            if (elig[c] && (!found || prio[c] < best)) begin
               best      = prio[c];
               found     = 1'b1;
               win_oh    = '0;
               win_oh[c] = 1'b1;
            end
         end
      end
   end

   assign win_any = found;
endmodule

// File: rtl/dmaarb_hold.sv
module dmaarb_hold
   import dmaarb_pkg::*;
#(
   parameter int unsigned NUM_CH = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] req,
   input  logic [NUM_CH-1:0] win_oh,
   input  logic              win_any,
   output logic [NUM_CH-1:0] grant
);
   arb_state_e        state_q, state_d;
   logic [NUM_CH-1:0] grant_d;
   logic              owner_req;

   assign owner_req = |(grant & req);

   always_comb begin
      state_d = state_q;
      grant_d = grant;
      unique case (state_q)
         ARB_IDLE: if (win_any) begin
            state_d = ARB_OWN;
            grant_d = win_oh;
         end
         ARB_OWN: if (!owner_req) begin
            state_d = ARB_IDLE;
            grant_d = '0;
         end
         default: begin
            state_d = ARB_IDLE;
            grant_d = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ARB_IDLE;
         grant   <= '0;
      end else begin
         state_q <= state_d;
         grant   <= grant_d;
      end
   end
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter #(
   parameter int unsigned NUM_CH  = 7,
   parameter int unsigned PRIO_W  = 3,
   parameter int unsigned REG_W   = 32,
   parameter logic [REG_W-1:0] RST_VAL = 32'h0765_4321,
   parameter bit          TIE_HIGH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic [REG_W-1:0]  cfg_rdata,
   input  logic [NUM_CH-1:0] req,
   output logic [NUM_CH-1:0] grant,
   output logic              grant_valid,
   output logic              cpu_stall
);
   localparam int unsigned FIELD_W = PRIO_W + 1;
   localparam int unsigned USED_W  = NUM_CH * FIELD_W;

   if (USED_W > REG_W) begin : g_bad_width
      $error("channel fields do not fit in the configuration word");
   end
   if (NUM_CH < 2 || NUM_CH > dmaarb_pkg::MAX_CH) begin : g_bad_count
      $error("channel count out of range");
   end

   logic [NUM_CH-1:0] win_oh;
   logic              win_any;

   dmaarb_cfg_reg #(.REG_W(REG_W), .RST_VAL(RST_VAL)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .q(cfg_rdata)
   );

   dmaarb_pick #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W), .TIE_HIGH(TIE_HIGH)) u_pick (
      .cfg(cfg_rdata[USED_W-1:0]), .req(req), .win_oh(win_oh), .win_any(win_any)
   );

   dmaarb_hold #(.NUM_CH(NUM_CH)) u_hold (
      .clk(clk), .rst_n(rst_n), .req(req), .win_oh(win_oh), .win_any(win_any),
      .grant(grant)
   );

   assign grant_valid = |grant;
   assign cpu_stall   = grant_valid;
endmodule

// File: rtl/dmaarb_checker.sv
module dmaarb_checker #(
   parameter int unsigned NUM_CH = 7,
   parameter int unsigned PRIO_W = 3,
   parameter int unsigned REG_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [REG_W-1:0]  cfg,
   input logic [NUM_CH-1:0] req,
   input logic [NUM_CH-1:0] grant,
   input logic              grant_valid,
   input logic              cpu_stall
);
   localparam int unsigned FIELD_W = PRIO_W + 1;
   logic [NUM_CH-1:0] en;
   logic unused_cfg_bits;
   assign unused_cfg_bits = ^cfg;
   for (genvar c = 0; c < NUM_CH; c++) begin : g_en
      assign en[c] = cfg[c*FIELD_W + PRIO_W];
   end

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R7
   AST_STALL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_stall == grant_valid) && (grant_valid == (grant != '0))); // R10
   AST_OWNER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && ((grant & req) != '0)) |=> $stable(grant)); // R8
   AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && ((grant & req) == '0)) |=> !grant_valid); // R9
   AST_NEW_GRANT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant_valid) |-> ((grant & $past(req) & $past(en)) != '0)); // R5
endmodule

bind dma_prio_arbiter dmaarb_checker #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W), .REG_W(REG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg(cfg_rdata), .req(req), .grant(grant),
   .grant_valid(grant_valid), .cpu_stall(cpu_stall)
);

// File: tb/tb_dma_prio_arbiter.sv
`timescale 1ns/1ps
module tb_dma_prio_arbiter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [6:0]  req = '0;
   logic [6:0]  grant;
   logic        grant_valid, cpu_stall;

   always #2.5 clk = ~clk;

   dma_prio_arbiter dut (.*);

   int checks = 0, fails = 0;
   bit done = 1'b0;

   // {cfg, req, expected grant}
   localparam int NV = 12;
   localparam logic [45:0] VEC [NV] = '{
      {32'h0FED_CBA9, 7'h7F, 7'h01},   // R2 R3 ch0 urgency 1 best
      {32'h0FED_CBA9, 7'h7E, 7'h02},   // R3
      {32'h0888_8888, 7'h15, 7'h10},   // R4 tie -> ch4
      {32'h0888_8888, 7'h7F, 7'h40},   // R4 tie -> ch6
      {32'h0888_888F, 7'h01, 7'h01},   // R3 sole requester at urgency 7
      {32'h0F0F_0F0F, 7'h0A, 7'h00},   // R5 only disabled channels request
      {32'h0F0F_0F0F, 7'h0B, 7'h01},   // R5 disabled ch1/ch3 skipped
      {32'h0FFF_FFFF, 7'h03, 7'h02},   // R4
      {32'h7FFF_FFFF, 7'h03, 7'h02},   // R6 spare bits no effect
      {32'hF888_8888, 7'h15, 7'h10},   // R6
      {32'h0A9B_CDEF, 7'h7F, 7'h20},   // R2 R3 ch5 urgency 1
      {32'h0A9B_CDEF, 7'h1F, 7'h10}    // R3 ch4 urgency 3
   };

   task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   task automatic wr_cfg(input logic [31:0] v);
      @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic step;
      @(posedge clk); @(negedge clk);
   endtask

   initial begin
      repeat (400000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 cfg", cfg_rdata, 32'h0765_4321);
      chk("R1 grant", {25'd0, grant}, 32'h0);
      chk("R1 stall", {30'd0, grant_valid, cpu_stall}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk); req = 7'h7F;
      step; step;
      chk("R1 all disabled", {25'd0, grant}, 32'h0);
      req = '0;

      // table walk
      for (int i = 0; i < NV; i++) begin
         wr_cfg(VEC[i][45:14]);
         req = VEC[i][13:7];
         step;
         chk("R3/R4/R5/R6 vector", {25'd0, grant}, {25'd0, VEC[i][6:0]});
         chk("R10 stall", {30'd0, grant_valid, cpu_stall},
             {30'd0, {2{|VEC[i][6:0]}}});
         req = '0;
         step; step;
      end

      // R6 spare bits read back
      wr_cfg(32'hA123_4567);
      chk("R6 readback", cfg_rdata, 32'hA123_4567);

      // R7 R8 R9 hold and release
      wr_cfg(32'h0FED_CBA9);
      req = 7'h08;
      step;
      chk("R7 grant same edge", {25'd0, grant}, 32'h08);
      req = 7'h0B;              // more urgent ch0 arrives
      step;
      chk("R8 hold", {25'd0, grant}, 32'h08);
      step;
      chk("R8 hold again", {25'd0, grant}, 32'h08);
      req = 7'h03;              // owner releases
      step;
      chk("R9 gap", {25'd0, grant}, 32'h0);
      chk("R10 gap stall", {31'd0, cpu_stall}, 32'h0);
      step;
      chk("R9 rearbitrate", {25'd0, grant}, 32'h01);
      req = '0;
      step; step;

      // R5 clearing enable of a lone requester
      wr_cfg(32'h0FED_CBA1);
      req = 7'h01;
      step; step;
      chk("R5 disabled lone", {25'd0, grant}, 32'h0);
      req = '0;

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule